// File: doc/BRIEF.md
# Instruction Immediate Operand Generator

This block turns a 32-bit base-integer instruction word into the 32-bit immediate operand that the execute stage consumes. Each encoding format scatters its constant across different instruction fields. The block gathers those pieces, puts them back in numeric order, fills in any implicit zero bits and sign-extends the result where the format calls for it.

The block does not look at the opcode. An external decoder chooses the format and passes that choice in on a small numeric select. The datapath is purely combinational, with no clock and no storage, so the operand is ready in the same cycle as the instruction word. It fits directly between a decoder and an operand multiplexer.

Top module: `rvimm_gen`

## Requirements
- R1: With select 0 (register-immediate format), the output is instruction bits 31:20 sign-extended from bit 31. For example, 0x7FF00000 gives 0x000007FF and 0xFFF00000 gives 0xFFFFFFFF.
- R2: With select 1 (store format), output bits 11:5 come from instruction bits 31:25 and output bits 4:0 come from instruction bits 11:7. The result is sign-extended from instruction bit 31.
- R3: With select 2 (conditional branch format), the output is built as follows: bit 0 is zero, bits 4:1 come from instruction 11:8, bits 10:5 from instruction 30:25, and bit 11 from instruction bit 7. Bits 31:12 all copy instruction bit 31.
- R4: With select 3 (upper immediate format), output bits 31:12 equal instruction bits 31:12 and output bits 11:0 are zero.
- R5: With select 4 (jump format), the output is built as follows: bit 0 is zero, bits 10:1 come from instruction 30:21, bit 11 from instruction bit 20, and bits 19:12 from instruction 19:12. Bits 31:20 all copy instruction bit 31.
- R6: Select values 5, 6 and 7 drive an output of zero for any instruction word.
- R7: The output depends only on the present inputs. It settles with no clock edge, in the same cycle the inputs change.
- R8: Instruction bits 6:0 never affect the output under any select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_word | input | 32 | Instruction word to extract the immediate from |
| fmt_sel | input | 3 | Format select: 0 register-immediate, 1 store, 2 branch, 3 upper, 4 jump, 5 to 7 unused |
| imm_out | output | 32 | Reassembled, extended immediate operand |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the inputs and the output. The bench applies inputs on the rising edge of its pacing clock and samples the output at the following falling edge, half a period later. No edge reaches the block in between. It compares each sample against a reference function that rebuilds the immediate arithmetically, using shifts and masks, for every select value. For R8, the bench toggles only the low seven instruction bits and checks the output before changing anything else.

// File: rtl/rvimm_pkg.sv
package rvimm_pkg;
  localparam int INST_W  = 32;
  localparam int SEL_W   = 3;
  localparam int NUM_FMT = 5;
  localparam int LOW_IGN = 7; // opcode bits that never feed an immediate

  typedef logic [INST_W-1:0] word_t;

  typedef enum logic [SEL_W-1:0] {
    FMT_REGIMM = 3'd0,
    FMT_STORE  = 3'd1,
    FMT_BRANCH = 3'd2,
    FMT_UPPER  = 3'd3,
    FMT_JUMP   = 3'd4
  } imm_fmt_e;
endpackage

// File: rtl/rvimm_unpack.sv
module rvimm_unpack
  import rvimm_pkg::*;
(
  input  logic [INST_W-1:LOW_IGN] field_i,
  output word_t                   cand_o [NUM_FMT]
);
  logic sgn;
  assign sgn = field_i[31];

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    if (f == int'(FMT_REGIMM)) begin : g_regimm
      assign cand_o[f] = {{20{sgn}}, field_i[31:20]};
    end else if (f == int'(FMT_STORE)) begin : g_store
      assign cand_o[f] = {{20{sgn}}, field_i[31:25], field_i[11:7]};
    end else if (f == int'(FMT_BRANCH)) begin : g_branch
      assign cand_o[f] = {{20{sgn}}, field_i[7], field_i[30:25],
                          field_i[11:8], 1'b0};
    end else if (f == int'(FMT_UPPER)) begin : g_upper
      assign cand_o[f] = {field_i[31:12], 12'h000};
    end else begin : g_jump
      assign cand_o[f] = {{12{sgn}}, field_i[19:12], field_i[20],
                          field_i[30:21], 1'b0};
    end
  end

  // Candidates whose format inserts an implicit low zero keep bit 0 clear.
  always_comb begin
    if (!$isunknown(field_i)) begin
      AST_LSB_ZERO: assert (cand_o[int'(FMT_BRANCH)][0] == 1'b0 &&
                            cand_o[int'(FMT_JUMP)][0] == 1'b0) // R3
        else $error("branch/jump candidate bit 0 set");
      AST_UPPER_LOW_ZERO: assert (cand_o[int'(FMT_UPPER)][11:0] == 12'h000) // R4
        else $error("upper candidate low bits not zero");
    end
  end
endmodule

// File: rtl/rvimm_select.sv
module rvimm_select
  import rvimm_pkg::*;
(
  input  word_t            cand_i [NUM_FMT],
  input  logic [SEL_W-1:0] sel_i,
  output word_t            out_o
);
  logic [NUM_FMT-1:0] hit;
  word_t              masked [NUM_FMT];

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_hit
    assign hit[f]    = (sel_i == SEL_W'(f));
    assign masked[f] = cand_i[f] & {INST_W{hit[f]}};
  end

  always_comb begin
    out_o = '0;
    for (int f = 0; f < NUM_FMT; f++) out_o = out_o | masked[f];
  end

  always_comb begin
    if (!$isunknown(sel_i)) begin
      AST_SEL_ONEHOT: assert ($onehot0(hit)) // R6
        else $error("more than one format selected");
      if (int'(sel_i) >= NUM_FMT) begin
        AST_UNUSED_ZERO: assert (out_o == '0) // R6
          else $error("unused select drove nonzero output");
      end
    end
  end
endmodule

// File: rtl/rvimm_gen.sv
module rvimm_gen
  import rvimm_pkg::*;
(
  input  logic [31:0] inst_word,
  input  logic [2:0]  fmt_sel,
  output logic [31:0] imm_out
);
  word_t cand [NUM_FMT];

  rvimm_unpack u_unpack (
    .field_i (inst_word[INST_W-1:LOW_IGN]),
    .cand_o  (cand)
  );

  rvimm_select u_select (
    .cand_i (cand),
    .sel_i  (fmt_sel),
    .out_o  (imm_out)
  );

  always_comb begin
    if (!$isunknown({inst_word, fmt_sel})) begin
      if (fmt_sel == FMT_REGIMM || fmt_sel == FMT_STORE ||
          fmt_sel == FMT_BRANCH || fmt_sel == FMT_JUMP) begin
        AST_SIGN_FOLLOWS: assert (imm_out[31] == inst_word[31]) // R1
          else $error("sign bit does not follow instruction bit 31");
      end
      if (fmt_sel == FMT_REGIMM) begin
        AST_REGIMM_EXT: assert ($countones(imm_out[31:11]) == 0 ||
                                $countones(imm_out[31:11]) == 21) // R1
          else $error("register-immediate extension broken");
        AST_REGIMM_LOW: assert (imm_out[10:0] == inst_word[30:20]) // R1
          else $error("register-immediate low field wrong");
      end
      if (fmt_sel == FMT_STORE) begin
        AST_STORE_LOW: assert (imm_out[4:0] == inst_word[11:7]) // R2
          else $error("store low field wrong");
      end
      if (fmt_sel == FMT_UPPER) begin
        AST_UPPER_HIGH: assert (imm_out[31:12] == inst_word[31:12]) // R4
          else $error("upper field wrong");
      end
      if (fmt_sel == FMT_JUMP) begin
        AST_JUMP_MID: assert (imm_out[19:12] == inst_word[19:12]) // R5
          else $error("jump middle field wrong");
      end
    end
  end
endmodule

// File: tb/rvimm_gen_tb_top.sv
module rvimm_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 50000;

  logic        clk = 1'b0;
  logic [31:0] inst_word;
  logic [2:0]  fmt_sel;
  logic [31:0] imm_out;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rvimm_gen dut_i (.inst_word(inst_word), .fmt_sel(fmt_sel), .imm_out(imm_out));

  function automatic logic [31:0] ref_imm(logic [31:0] w, int s);
    logic [31:0] sx;
    sx = 32'($signed(w) >>> 31);
    case (s)
      0: return 32'($signed(w) >>> 20);
      1: return (32'($signed(w) >>> 25) << 5) | 32'(w[11:7]);
      2: return (sx << 12) | (32'(w[7]) << 11) | (32'(w[30:25]) << 5) | (32'(w[11:8]) << 1);
      3: return w & 32'hFFFF_F000;
      4: return (sx << 20) | (32'(w[19:12]) << 12) | (32'(w[20]) << 11) | (32'(w[30:21]) << 1);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s inst=%h sel=%0d got=%h exp=%h", tag, inst_word, fmt_sel, got, exp);
    end
  endtask

  function automatic string tag_of(int s);
    case (s)
      0: return "R1"; 1: return "R2"; 2: return "R3";
      3: return "R4"; 4: return "R5"; default: return "R6";
    endcase
  endfunction

  // drive on rising edge, sample at the falling edge of the same cycle
  task automatic apply(logic [31:0] w, int s, string tag);
    @(posedge clk);
    inst_word = w;
    fmt_sel   = 3'(s);
    @(negedge clk);
    check(tag, imm_out, ref_imm(w, s));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_CYC) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=%0d exp<=%0d", cyc, WDOG_CYC);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    inst_word = '0;
    fmt_sel   = '0;
    @(negedge clk);
    check("R1", imm_out, 32'h0); // all-zero inputs give zero

    // directed corners
    apply(32'h7FF0_0000, 0, "R1");
    check("R1", imm_out, 32'h0000_07FF);
    apply(32'hFFF0_0000, 0, "R1");
    check("R1", imm_out, 32'hFFFF_FFFF);
    apply(32'h000F_FFFF, 0, "R1");
    apply(32'hFE00_0F80, 1, "R2");
    check("R2", imm_out, 32'hFFFF_FFFF);
    apply(32'h01FF_F07F, 1, "R2");
    apply(32'hC000_0F00, 2, "R3");
    check("R3", imm_out, 32'hFFFF_F41E);
    apply(32'hFFFF_FFFF, 2, "R3");
    apply(32'hFFFF_F000, 3, "R4");
    check("R4", imm_out, 32'hFFFF_F000);
    apply(32'h0000_0FFF, 3, "R4");
    apply(32'h4009_9000, 4, "R5");
    check("R5", imm_out, 32'h0009_9400);
    apply(32'hFFFF_F000, 4, "R5");
    check("R5", imm_out, 32'hFFFF_FFFE);
    apply(32'hFFFF_FFFF, 5, "R6");
    apply(32'hFFFF_FFFF, 7, "R6");

    // R7: input change without any clock edge shows up in the output
    @(negedge clk);
    inst_word = 32'h8000_0000; fmt_sel = 3'd3;
    #1 check("R7", imm_out, 32'h8000_0000);
    fmt_sel = 3'd0;
    #1 check("R7", imm_out, 32'hFFFF_F800);

    // R8: low opcode bits toggled alone leave the output unchanged
    for (int s = 0; s < 8; s++) begin
      w = $urandom();
      apply(w & 32'hFFFF_FF80, s, "R8");
      @(negedge clk);
      inst_word = w | 32'h0000_007F;
      #1 check("R8", imm_out, ref_imm(w & 32'hFFFF_FF80, s));
    end

    // constrained random per select value
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 150; k++) begin
        w = $urandom();
        if (k % 4 == 0) w[31] = 1'b1;
        if (k % 4 == 1) w[31] = 1'b0;
        apply(w, s, tag_of(s));
      end
    end

    finish_run();
  end
endmodule